// File: doc/BRIEF.md
# Three-Wire SPI Slave with Idle-Timeout Framing

This block is an SPI slave for a bus with no slave-select line: the select is treated as permanently asserted, so the block must be the only slave on the bus. A fast system clock oversamples the serial clock and the host data line. Both pass through synchronisers before edge detection. A frame begins at the first falling serial-clock edge that follows a long enough idle period, and it ends when the serial clock stays high past a timeout. Both limits are parameters in nanoseconds and are converted to system-clock cycle counts. Received bytes are delivered most significant bit first on a valid strobe. The block also reports when a frame starts, when each byte is complete and when a frame ends.

Transmit bytes come from a ready/valid byte port into a small staging buffer. The upstream logic always presents multi-byte data least significant byte first. A byte presented with the reverse flag opens a group of four bytes, and that group is sent most significant byte first, which is the order a 32-bit checksum needs. The block flags three protocol faults. A frame that starts too soon after the previous one is ignored and sets a sticky flag. A missing transmit byte is sent as zero and flagged. A frame that stops partway through a byte is flagged.

The control machine has three states. IDLE waits for a falling edge. XFER is an accepted transfer. SKIP is a transfer being ignored. The transitions are:
- IDLE to XFER (start) on a falling edge after enough idle time.
- IDLE to SKIP (violate) on a falling edge that comes too early.
- XFER to IDLE (finish) when the high-time timeout expires.
- SKIP to IDLE (drop) when the same timeout expires.

Top module: `spi3w_slave`

## Requirements
- R1: After reset, miso, rx_valid, frame_start, frame_end, frame_err, underrun and gap_err are all 0, and tx_ready is 1.
- R2: A falling serial-clock edge in IDLE, after the clock has been high for at least GAP_NS, raises frame_start for one cycle and moves to XFER.
- R3: In XFER the host data line is sampled on each rising serial-clock edge, most significant bit first. After every eighth rising edge, rx_valid pulses for one cycle with the assembled byte on rx_data.
- R4: At the first falling edge of each byte slot, a transmit byte is loaded and its bit 7 is driven on miso. Each following falling edge drives the next lower bit. miso changes only after falling edges.
- R5: In XFER, when the serial clock stays high for END_NS, frame_end pulses for one cycle and the machine returns to IDLE.
- R6: A falling edge in IDLE after less than GAP_NS of high time sets gap_err, and gap_err stays set until reset. That transfer produces no frame_start, no frame_end and no rx_valid, and it consumes no transmit byte.
- R7: If the frame ends with a partial byte, the incomplete byte produces no rx_valid, and frame_err is 1 from frame_end until the next frame_start. A frame that ends on a whole byte gives frame_err 0.
- R8: If no transmit byte is staged at a byte boundary, 0x00 is shifted out and underrun is set. underrun is held until the next frame_start, which sets it again if the first byte is missing.
- R9: A byte accepted with tx_rev=1 while the staging buffer is empty opens a four-byte group. The group is accepted in order B0 to B3 and sent as B3, B2, B1, B0. A byte accepted with tx_rev=0 into an empty buffer is sent alone.
- R10: All staged transmit bytes are discarded at frame end.
- R11: tx_ready is 0 while a single byte or a complete group is waiting to be sent. It is 1 while the buffer is empty or a group is still being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte is offered |
| tx_rev | input | 1 | Byte opens a reversed four-byte group |
| tx_ready | output | 1 | Staging buffer accepts a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe, rx_data holds a whole byte |
| frame_start | output | 1 | One-cycle strobe when a frame is accepted |
| frame_end | output | 1 | One-cycle strobe when a frame times out |
| frame_err | output | 1 | Last frame ended on a partial byte |
| underrun | output | 1 | A byte slot in this frame had no staged data |
| gap_err | output | 1 | Sticky: a transfer began too soon after the previous one |

## Verification
A wrong bit counter shows up within one byte: the rx_data value is wrong, or the byte captured from miso is shifted, on the very next rx_valid. A wrong idle-timer threshold shows up at the end of the frame. frame_end either never appears, which is caught by the frame count check after the wait, or a too-early transfer is accepted without gap_err. Errors in the staging buffer (group order, flushing, byte consumption by an ignored frame) show up in the first miso byte of the next frame, because the bench compares every shifted-out byte with an order it computes from the bytes it fed.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

    // Link control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // serial clock idle, waiting for a falling edge
        ST_XFER = 2'd1,   // accepted transfer in progress
        ST_SKIP = 2'd2    // transfer started too early, ignored
    } link_state_e;

endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic mosi_in,
    output logic sclk_lvl,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_lvl
);

    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic              sclk_prev;

    // Serial clock resets to its idle-high level so no false edge appears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_pipe <= '1;
            mosi_pipe <= '0;
            sclk_prev <= 1'b1;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_in};
            mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_in};
            sclk_prev <= sclk_pipe[STAGES-1];
        end
    end

    assign sclk_lvl  = sclk_pipe[STAGES-1];
    assign mosi_lvl  = mosi_pipe[STAGES-1];
    assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_prev;
    assign sclk_fall = ~sclk_pipe[STAGES-1] & sclk_prev;

endmodule

// File: rtl/spi3w_idle_timer.sv
module spi3w_idle_timer #(
    parameter int END_CYC = 1000,
    parameter int GAP_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_lvl,
    output logic end_hit,
    output logic gap_ok
);

    localparam int CW = $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] GAP_V = CW'(GAP_CYC);
    localparam logic [CW-1:0] END_V = CW'(END_CYC);

    logic [CW-1:0] hi_cnt;

    // Counts serial-clock high cycles and saturates at the gap limit.
    // It starts saturated so that the first frame after reset is legal.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= GAP_V;
        end else if (!sclk_lvl) begin
            hi_cnt <= '0;
        end else if (hi_cnt < GAP_V) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign end_hit = sclk_lvl && (hi_cnt >= END_V);
    assign gap_ok  = (hi_cnt >= GAP_V);

    // R5: the counter never goes past its saturation point
    a_r5_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= GAP_V);

endmodule

// File: rtl/spi3w_tx_stage.sv
module spi3w_tx_stage #(
    parameter int BW  = 8,
    parameter int GRP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] in_data,
    input  logic          in_valid,
    input  logic          in_rev,
    output logic          in_ready,
    input  logic          pop,
    input  logic          flush,
    output logic [BW-1:0] head,
    output logic          avail
);

    localparam int FW = $clog2(GRP + 1);

    logic [BW-1:0] slot [GRP];
    logic [FW-1:0] fill;
    logic          grp_mode;
    logic          avail_q;
    logic          take;

    assign in_ready = !avail_q && ((fill == '0) || grp_mode);
    assign take     = in_valid && in_ready;
    assign avail    = avail_q;

    // The next byte to send is always the highest filled slot.
    // A single byte sits in slot 0, and a group drains from the top down.
    always_comb begin
        head = '0;
        for (int k = 0; k < GRP; k++) begin
            if (fill == FW'(k + 1)) head = slot[k];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < GRP; k++) begin
            if (take && !flush && fill == FW'(k)) slot[k] <= in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill     <= '0;
            grp_mode <= 1'b0;
            avail_q  <= 1'b0;
        end else if (flush) begin
            fill     <= '0;
            grp_mode <= 1'b0;
            avail_q  <= 1'b0;
        end else if (pop) begin
            fill    <= fill - 1'b1;
            avail_q <= (fill > FW'(1));
            if (fill == FW'(1)) grp_mode <= 1'b0;
        end else if (take) begin
            fill <= fill + 1'b1;
            if (fill == '0) begin
                grp_mode <= in_rev;
                avail_q  <= !in_rev;
            end else begin
                avail_q  <= (fill == FW'(GRP - 1));
            end
        end
    end

    a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(GRP));
    a_r8_pop_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> avail_q);
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0) && !avail_q);
    a_r11_held_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_q && !pop && !flush) |=> (fill == $past(fill)));

endmodule

// File: rtl/spi3w_slave.sv
module spi3w_slave
    import spi3w_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int END_NS      = 5000,
    parameter int GAP_NS      = 10000,
    parameter int BYTE_W      = 8,
    parameter int GRP_BYTES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_rev,
    output logic              tx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_start,
    output logic              frame_end,
    output logic              frame_err,
    output logic              underrun,
    output logic              gap_err
);

    localparam int END_CYC = CLK_MHZ * END_NS / 1000;
    localparam int GAP_CYC = CLK_MHZ * GAP_NS / 1000;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    link_state_e state, state_nx;

    logic              sclk_lvl, sclk_rise, sclk_fall, mosi_lvl;
    logic              end_hit, gap_ok;
    logic              avail, pop, flush;
    logic [BYTE_W-1:0] head, next_byte;
    logic              fall_start, fall_early, load_tx;

    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic [CNT_W-1:0]  rx_cnt, tx_cnt;
    logic              miso_q;

    spi3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk),
        .mosi_in   (mosi),
        .sclk_lvl  (sclk_lvl),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_lvl  (mosi_lvl)
    );

    spi3w_idle_timer #(.END_CYC(END_CYC), .GAP_CYC(GAP_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_lvl (sclk_lvl),
        .end_hit  (end_hit),
        .gap_ok   (gap_ok)
    );

    spi3w_tx_stage #(.BW(BYTE_W), .GRP(GRP_BYTES)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (tx_data),
        .in_valid (tx_valid),
        .in_rev   (tx_rev),
        .in_ready (tx_ready),
        .pop      (pop),
        .flush    (flush),
        .head     (head),
        .avail    (avail)
    );

    // Edge qualifiers and datapath controls
    always_comb begin
        fall_start = (state == ST_IDLE) && sclk_fall && gap_ok;
        fall_early = (state == ST_IDLE) && sclk_fall && !gap_ok;
        load_tx    = fall_start || ((state == ST_XFER) && sclk_fall && (tx_cnt == '0));
        pop        = load_tx && avail;
        flush      = (state == ST_XFER) && end_hit;
        next_byte  = avail ? head : '0;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (fall_start)      state_nx = ST_XFER;   // start
                else if (fall_early) state_nx = ST_SKIP;   // violate
            end
            ST_XFER: if (end_hit) state_nx = ST_IDLE;      // finish
            ST_SKIP: if (end_hit) state_nx = ST_IDLE;      // drop
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh       <= '0;
            tx_sh       <= '0;
            rx_cnt      <= '0;
            tx_cnt      <= '0;
            miso_q      <= 1'b0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            frame_err   <= 1'b0;
            underrun    <= 1'b0;
            gap_err     <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            rx_valid    <= 1'b0;

            if (load_tx) begin
                miso_q <= next_byte[BYTE_W-1];
                tx_sh  <= {next_byte[BYTE_W-2:0], 1'b0};
                tx_cnt <= CNT_W'(1);
                if (!avail) underrun <= 1'b1;
            end else if ((state == ST_XFER) && sclk_fall) begin
                miso_q <= tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                tx_cnt <= tx_cnt + 1'b1;
            end

            if (fall_start) begin
                frame_start <= 1'b1;
                frame_err   <= 1'b0;
                rx_cnt      <= '0;
                underrun    <= !avail;
            end

            if (fall_early) gap_err <= 1'b1;

            if ((state == ST_XFER) && sclk_rise) begin
                rx_sh  <= {rx_sh[BYTE_W-2:0], mosi_lvl};
                rx_cnt <= rx_cnt + 1'b1;
                if (rx_cnt == LAST_BIT) begin
                    rx_valid <= 1'b1;
                    rx_data  <= {rx_sh[BYTE_W-2:0], mosi_lvl};
                end
            end

            if (flush) begin
                frame_end <= 1'b1;
                frame_err <= (rx_cnt != '0);
                miso_q    <= 1'b0;
            end
        end
    end

    assign miso = miso_q;

    a_r2_start_enters_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (state == ST_XFER));
    a_r5_end_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (state == ST_IDLE));
    a_r5_start_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && frame_end));
    a_r3_rx_only_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (state == ST_XFER));
    a_r6_gap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(gap_err));
    a_r6_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!frame_start && !rx_valid && !pop));
    a_r4_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sclk_fall) && !$past(flush)) |-> $stable(miso_q));

endmodule

// File: tb/tb_spi3w_slave.sv
`timescale 1ns/1ps
module tb_spi3w_slave;

    localparam int HALF  = 5;     // system cycles per serial clock phase
    localparam int END_C = 100;   // 500 ns at 200 MHz
    localparam int GAP_C = 200;   // 1000 ns at 200 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1;
    logic       mosi = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_rev = 1'b0;
    logic       miso, tx_ready, rx_valid, frame_start, frame_end;
    logic       frame_err, underrun, gap_err;
    logic [7:0] rx_data;

    always #2.5 clk = ~clk;

    spi3w_slave #(.CLK_MHZ(200), .END_NS(500), .GAP_NS(1000)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .miso(miso),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_rev(tx_rev), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_start(frame_start),
        .frame_end(frame_end), .frame_err(frame_err), .underrun(underrun),
        .gap_err(gap_err)
    );

    int errs = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Upstream byte feeder
    logic [7:0] feed_d [0:31];
    bit         feed_r [0:31];
    int         feed_n = 0;
    int         feed_gen = 0;
    int         seen_gen = 0;
    int         feed_i = 0;
    bit         will_acc = 1'b0;

    always @(negedge clk) begin
        if (seen_gen != feed_gen) begin
            seen_gen = feed_gen;
            feed_i   = 0;
            will_acc = 1'b0;
        end else if (will_acc) begin
            feed_i++;
        end
        if (feed_i < feed_n) begin
            tx_valid = 1'b1;
            tx_data  = feed_d[feed_i];
            tx_rev   = feed_r[feed_i];
        end else begin
            tx_valid = 1'b0;
            tx_rev   = 1'b0;
        end
        will_acc = tx_valid && tx_ready;
    end

    // Output monitor
    logic [7:0] rx_q [0:255];
    int rx_n = 0, fs_n = 0, fe_n = 0;
    bit fe_err = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_n < 256) begin
                rx_q[rx_n] = rx_data;
                rx_n++;
            end
            if (frame_start) fs_n++;
            if (frame_end) begin
                fe_n++;
                fe_err = frame_err;
            end
        end
    end

    // Host side
    logic [7:0] m_d [0:15];
    logic [7:0] miso_cap [0:15];
    logic [7:0] exp_q [0:39];
    int rx_base, fs_base, fe_base;

    task automatic host_bits(input int nbits);
        for (int k = 0; k < 16; k++) miso_cap[k] = 8'h00;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            sclk = 1'b0;
            mosi = m_d[b / 8][7 - (b % 8)];
            repeat (HALF - 1) @(negedge clk);
            miso_cap[b / 8][7 - (b % 8)] = miso;
            @(negedge clk);
            sclk = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic do_frame(input int nbits, input int post);
        rx_base = rx_n;
        fs_base = fs_n;
        fe_base = fe_n;
        host_bits(nbits);
        feed_n = 0;
        feed_gen++;
        repeat (post) @(negedge clk);
    endtask

    task automatic feed_start(input int n);
        feed_n = n;
        feed_gen++;
        repeat (16) @(negedge clk);
    endtask

    // Expected MISO byte order from the fed bytes and the group rule
    task automatic build_exp(input int n_out);
        int i = 0;
        int k = 0;
        while (k < n_out) begin
            if (i < feed_n) begin
                if (feed_r[i]) begin
                    for (int j = 3; j >= 0; j--) begin
                        exp_q[k] = feed_d[i + j];
                        k++;
                    end
                    i += 4;
                end else begin
                    exp_q[k] = feed_d[i];
                    k++;
                    i++;
                end
            end else begin
                exp_q[k] = 8'h00;
                k++;
            end
        end
    endtask

    task automatic check_bytes(input int nbytes);
        chk(fs_n == fs_base + 1, "R2 frame_start count", fs_n - fs_base, 1);
        chk(fe_n == fe_base + 1, "R5 frame_end count", fe_n - fe_base, 1);
        chk(rx_n == rx_base + nbytes, "R3 rx byte count", rx_n - rx_base, nbytes);
        for (int k = 0; k < nbytes; k++) begin
            chk(rx_q[rx_base + k] == m_d[k], "R3 rx byte", rx_q[rx_base + k], m_d[k]);
            chk(miso_cap[k] == exp_q[k], "R4/R9 miso byte", miso_cap[k], exp_q[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(miso == 1'b0 && rx_valid == 1'b0 && frame_start == 1'b0 && frame_end == 1'b0,
            "R1 outputs idle", {miso, rx_valid, frame_start, frame_end}, 0);
        chk(frame_err == 1'b0 && underrun == 1'b0 && gap_err == 1'b0,
            "R1 flags clear", {frame_err, underrun, gap_err}, 0);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);

        // Directed: four single bytes
        feed_d[0] = 8'hA5; feed_d[1] = 8'h3C; feed_d[2] = 8'hFF; feed_d[3] = 8'h01;
        for (int k = 0; k < 4; k++) feed_r[k] = 1'b0;
        m_d[0] = 8'h81; m_d[1] = 8'h7E; m_d[2] = 8'h00; m_d[3] = 8'hC3;
        feed_start(4);
        chk(tx_ready == 1'b0, "R11 ready low with staged byte", tx_ready, 0);
        build_exp(4);
        do_frame(32, END_C + GAP_C + 20);
        check_bytes(4);
        chk(fe_err == 1'b0, "R7 whole-byte frame", fe_err, 0);
        chk(underrun == 1'b0, "R8 no underrun", underrun, 0);

        // Directed R9: reversed group then a single byte
        feed_d[0] = 8'h11; feed_d[1] = 8'h22; feed_d[2] = 8'h33; feed_d[3] = 8'h44; feed_d[4] = 8'h99;
        for (int k = 0; k < 4; k++) feed_r[k] = 1'b1;
        feed_r[4] = 1'b0;
        feed_n = 5;
        feed_gen++;
        @(negedge clk);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R11 ready while collecting group", tx_ready, 1);
        repeat (14) @(negedge clk);
        for (int k = 0; k < 5; k++) m_d[k] = 8'(k * 37 + 5);
        build_exp(5);
        chk(exp_q[0] == 8'h44 && exp_q[3] == 8'h11, "R9 bench order", exp_q[0], 8'h44);
        do_frame(40, END_C + GAP_C + 20);
        check_bytes(5);

        // R7 partial byte
        feed_d[0] = 8'h6B; feed_d[1] = 8'h2D; feed_d[2] = 8'hE0;
        for (int k = 0; k < 3; k++) feed_r[k] = 1'b0;
        m_d[0] = 8'h5A; m_d[1] = 8'hF0; m_d[2] = 8'hFF;
        feed_start(3);
        do_frame(20, END_C + GAP_C + 20);
        chk(rx_n == rx_base + 2, "R7 partial byte dropped", rx_n - rx_base, 2);
        chk(fe_err == 1'b1 && frame_err == 1'b1, "R7 frame_err set", frame_err, 1);

        // Random frames
        for (int f = 0; f < 6; f++) begin
            int tot = 0;
            int lim = 1 + ($urandom % 8);
            while (tot < lim) begin
                if (($urandom % 3) == 0 && tot + 4 <= 8) begin
                    for (int j = 0; j < 4; j++) begin
                        feed_d[tot] = 8'($urandom);
                        feed_r[tot] = 1'b1;
                        tot++;
                    end
                end else begin
                    feed_d[tot] = 8'($urandom);
                    feed_r[tot] = 1'b0;
                    tot++;
                end
            end
            for (int k = 0; k < tot; k++) m_d[k] = 8'($urandom);
            feed_start(tot);
            build_exp(tot);
            do_frame(tot * 8, END_C + GAP_C + 20);
            check_bytes(tot);
            chk(fe_err == 1'b0, "R7 clean frame", fe_err, 0);
            chk(underrun == 1'b0, "R8 fed frame", underrun, 0);
        end

        // R8 underrun: one byte fed, three sent
        feed_d[0] = 8'hAA; feed_r[0] = 1'b0;
        m_d[0] = 8'h12; m_d[1] = 8'h34; m_d[2] = 8'h56;
        feed_start(1);
        build_exp(3);
        do_frame(24, END_C + GAP_C + 20);
        check_bytes(3);
        chk(underrun == 1'b1, "R8 underrun flag", underrun, 1);

        // R10 flush: three fed, one sent, leftovers must vanish
        feed_d[0] = 8'hC1; feed_d[1] = 8'hC2; feed_d[2] = 8'hC3;
        for (int k = 0; k < 3; k++) feed_r[k] = 1'b0;
        m_d[0] = 8'h0F;
        feed_start(3);
        do_frame(8, END_C + GAP_C + 20);
        chk(miso_cap[0] == 8'hC1, "R4 first byte", miso_cap[0], 8'hC1);
        repeat (16) @(negedge clk);
        m_d[0] = 8'hF0;
        do_frame(8, END_C + 20);   // short wait: sets up the gap test
        chk(miso_cap[0] == 8'h00, "R10 staging flushed", miso_cap[0], 0);
        chk(underrun == 1'b1, "R10 empty after flush", underrun, 1);

        // R6 gap violation: transfer starts too soon and is ignored
        feed_d[0] = 8'h5A; feed_r[0] = 1'b0;
        feed_n = 1;
        feed_gen++;
        repeat (4) @(negedge clk);
        m_d[0] = 8'h77;
        do_frame(8, END_C + GAP_C + 20);
        chk(gap_err == 1'b1, "R6 gap_err set", gap_err, 1);
        chk(fs_n == fs_base && fe_n == fe_base, "R6 no frame strobes", fs_n - fs_base, 0);
        chk(rx_n == rx_base, "R6 no rx bytes", rx_n - rx_base, 0);

        // The next legal frame still sees the untouched staged byte
        m_d[0] = 8'h3E;
        do_frame(8, END_C + GAP_C + 20);
        chk(fs_n == fs_base + 1, "R2 legal frame after gap", fs_n - fs_base, 1);
        chk(miso_cap[0] == 8'h5A, "R6 byte not consumed", miso_cap[0], 8'h5A);
        chk(rx_q[rx_base] == 8'h3E, "R3 rx after gap", rx_q[rx_base], 8'h3E);
        chk(gap_err == 1'b1, "R6 gap_err sticky", gap_err, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule